// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block collects level-sensitive interrupt requests from a fixed set of devices and merges them onto four shared interrupt lines. Every device has four request pins. Each pin is routed to one line by a rotation based on slot number: the pin index is added to the device's slot number modulo four. If the device sits behind one or more bridges, the same rotation is applied again at every hop, using the slot of the bridge at that hop, until the root is reached. The device topology (slot numbers and hop counts) is fixed by parameters.

The block does not OR the pins together. It keeps the last sampled level of every pin and holds, for each line, a counter of how many routed pins are currently high. A pin that changes level moves its line's counter up or down by one. Several changes in one cycle are summed per line. A line is driven high while its counter is non-zero. The counters are also brought out for debug. A pin level sampled at clock edge k shows on the counters and lines just after edge k.

Top module: `irq_line_agg`

## Requirements
- R1: After reset, and while reset is held, every line counter reads zero and every line output is low.
- R2: A pin that goes from 0 to 1 raises its routed line's counter by exactly one, visible after the clock edge that samples the new level.
- R3: A pin that goes from 1 to 0 lowers its routed line's counter by exactly one, visible after the clock edge that samples the new level.
- R4: A pin whose sampled level equals its previously recorded level leaves every counter unchanged.
- R5: Line output l is high exactly when counter l is non-zero.
- R6: Pin p (0..3) of a device attached directly to the root, with slot s, routes to line (p + s) mod 4. Pin p of device d is input bit d*4+p, and line l's counter sits at bits l*CNT_W upward in cnt_o.
- R7: For a device behind bridges, the rotation is applied once per hop: first with the device's own slot, then with each bridge's slot in turn, each step modulo 4.
- R8: All pin changes sampled in one cycle are applied together. The sum of all counters always equals the number of pins high at the previous edge. A rise and a fall on the same line in one cycle leave that counter unchanged.
- R9: A counter never wraps below zero; a decrement that would underflow clamps to zero and is flagged as an error.
- R10: Counters are ceil(log2(N_DEV*4+1)) bits wide and hold every value up to N_DEV*4, including the case where every pin is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears recorded pin levels and counters |
| pin_i | input | N_DEV*4 | Pin levels; device d pin p at bit d*4+p |
| line_o | output | 4 | Shared line levels, high while that line's counter is non-zero |
| cnt_o | output | 4*CNT_W | Per-line asserted-pin counters for debug, line l at bits l*CNT_W upward |

## Verification
The temporal properties assume that every pin is low while reset is asserted. Reset clears the recorded levels to zero, so a pin held high through reset would register as a rise on the first edge after release. That rise is correct behaviour, but a stable-input property would see it as a change. The stimulus forces all pins low in the same cycle reset is asserted and keeps them low until release. A behavioural model recounts the sampled pins per line using its own routing table each cycle, so directed bursts and long random toggling are both checked against an independent count.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_LINES    = 4;
  localparam int PINS_PER_DEV = 4;
  localparam int LINE_W       = 2;
  localparam int SLOT_W       = 5;

  // one rotation step of the slot swizzle
  function automatic int swizzle(int pin, int slot);
    return (pin + slot) % NUM_LINES;
  endfunction
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
  parameter int PINS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] lvl_i,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);
  logic [PINS-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~last_q;
  assign fall_o = ~lvl_i & last_q;
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_agg_pkg::*;
#(
  parameter int N_DEV    = 6,
  parameter int MAX_HOPS = 2,
  parameter int HOP_W    = 2,
  parameter int CNT_W    = 5,
  parameter logic [N_DEV*MAX_HOPS*SLOT_W-1:0] DEV_PATH = '0,
  parameter logic [N_DEV*HOP_W-1:0]           DEV_HOPS = '0
) (
  input  logic [N_DEV*PINS_PER_DEV-1:0] rise_i,
  input  logic [N_DEV*PINS_PER_DEV-1:0] fall_i,
  output logic [NUM_LINES*CNT_W-1:0]    up_o,
  output logic [NUM_LINES*CNT_W-1:0]    dn_o
);
  localparam int NPINS = N_DEV * PINS_PER_DEV;

  function automatic int map_pin(int d, int p);
    int l;
    int hops;
    l    = p;
    hops = int'(DEV_HOPS[d*HOP_W +: HOP_W]);
    for (int h = 0; h < MAX_HOPS; h++)
      if (h < hops) l = swizzle(l, int'(DEV_PATH[(d*MAX_HOPS+h)*SLOT_W +: SLOT_W]));
    return l;
  endfunction

  logic [LINE_W-1:0] pin_line [NPINS];

  for (genvar gd = 0; gd < N_DEV; gd++) begin : g_dev
    for (genvar gp = 0; gp < PINS_PER_DEV; gp++) begin : g_pin
      localparam int LINE_IDX = map_pin(gd, gp);
      assign pin_line[gd*PINS_PER_DEV+gp] = LINE_W'(LINE_IDX);
    end
  end

  always_comb begin
    logic [CNT_W-1:0] up_v;
    logic [CNT_W-1:0] dn_v;
    up_o = '0;
    dn_o = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      up_v = '0;
      dn_v = '0;
      for (int i = 0; i < NPINS; i++) begin
        if (int'(pin_line[i]) == l) begin
          up_v = up_v + CNT_W'(rise_i[i]);
          dn_v = dn_v + CNT_W'(fall_i[i]);
        end
      end
      up_o[l*CNT_W +: CNT_W] = up_v;
      dn_o[l*CNT_W +: CNT_W] = dn_v;
    end
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] up_i,
  input  logic [CNT_W-1:0] dn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             line_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   diff;

  assign sum     = {1'b0, cnt_q} + {1'b0, up_i};
  assign uflow_o = sum < {1'b0, dn_i};
  assign diff    = sum - {1'b0, dn_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (uflow_o) cnt_q <= '0;
    else              cnt_q <= diff[CNT_W-1:0];
  end

  assign cnt_o  = cnt_q;
  assign line_o = cnt_q != '0;
endmodule

// File: rtl/irq_line_agg.sv
module irq_line_agg
  import irq_agg_pkg::*;
#(
  parameter int N_DEV    = 6,
  parameter int MAX_HOPS = 2,
  parameter int HOP_W    = $clog2(MAX_HOPS + 1),
  parameter int CNT_W    = $clog2(N_DEV * PINS_PER_DEV + 1),
  // slot of device d at hop h lives at bits (d*MAX_HOPS+h)*SLOT_W; hop 0 is the device itself
  parameter logic [N_DEV*MAX_HOPS*SLOT_W-1:0] DEV_PATH =
    {5'd5, 5'd7, 5'd5, 5'd1, 5'd0, 5'd4, 5'd0, 5'd3, 5'd0, 5'd2, 5'd0, 5'd1},
  parameter logic [N_DEV*HOP_W-1:0] DEV_HOPS =
    {2'd2, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_DEV*PINS_PER_DEV-1:0] pin_i,
  output logic [NUM_LINES-1:0]          line_o,
  output logic [NUM_LINES*CNT_W-1:0]    cnt_o
);
  localparam int NPINS = N_DEV * PINS_PER_DEV;

  logic [NPINS-1:0]           rise;
  logic [NPINS-1:0]           fall;
  logic [NUM_LINES*CNT_W-1:0] up;
  logic [NUM_LINES*CNT_W-1:0] dn;
  logic [NUM_LINES-1:0]       uflow;

  for (genvar gd = 0; gd < N_DEV; gd++) begin : g_trk
    irq_pin_track #(.PINS(PINS_PER_DEV)) u_trk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (pin_i[gd*PINS_PER_DEV +: PINS_PER_DEV]),
      .rise_o (rise[gd*PINS_PER_DEV +: PINS_PER_DEV]),
      .fall_o (fall[gd*PINS_PER_DEV +: PINS_PER_DEV])
    );
  end

  irq_route #(
    .N_DEV    (N_DEV),
    .MAX_HOPS (MAX_HOPS),
    .HOP_W    (HOP_W),
    .CNT_W    (CNT_W),
    .DEV_PATH (DEV_PATH),
    .DEV_HOPS (DEV_HOPS)
  ) u_route (
    .rise_i (rise),
    .fall_i (fall),
    .up_o   (up),
    .dn_o   (dn)
  );

  for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
    irq_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .up_i    (up[gl*CNT_W +: CNT_W]),
      .dn_i    (dn[gl*CNT_W +: CNT_W]),
      .cnt_o   (cnt_o[gl*CNT_W +: CNT_W]),
      .line_o  (line_o[gl]),
      .uflow_o (uflow[gl])
    );
  end
endmodule

// File: rtl/irq_line_agg_chk.sv
module irq_line_agg_chk #(
  parameter int N_DEV = 6,
  parameter int CNT_W = $clog2(N_DEV * 4 + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_DEV*4-1:0]   pin_i,
  input logic [3:0]           line_o,
  input logic [4*CNT_W-1:0]   cnt_o,
  input logic [3:0]           uflow_i
);
  logic [CNT_W+2:0] total;

  always_comb begin
    total = '0;
    for (int l = 0; l < 4; l++) total = total + (CNT_W+3)'(cnt_o[l*CNT_W +: CNT_W]);
  end

  AST_STEADY_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pin_i) |=> $stable(cnt_o)); // R4

  AST_SUM_MATCHES_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(total) == $countones($past(pin_i))); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_i == 4'b0000); // R9

  AST_LINE_NEEDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|line_o) |-> (|$past(pin_i))); // R5

  for (genvar gl = 0; gl < 4; gl++) begin : g_bound
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_o[gl*CNT_W +: CNT_W]) <= N_DEV * 4); // R10
  end
endmodule

bind irq_line_agg irq_line_agg_chk #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pin_i   (pin_i),
  .line_o  (line_o),
  .cnt_o   (cnt_o),
  .uflow_i (uflow)
);

// File: tb/tb_irq_line_agg.sv
module tb_irq_line_agg;
  localparam int N_DEV = 6;
  localparam int NP    = N_DEV * 4;
  localparam int CW    = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin_drv = '0;
  logic [3:0]    line_o;
  logic [4*CW-1:0] cnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit running = 0;

  // independent topology: own slot, bridge slot, hop count
  int slot0 [N_DEV] = '{1, 2, 3, 4, 1, 7};
  int slot1 [N_DEV] = '{0, 0, 0, 0, 5, 5};
  int hops  [N_DEV] = '{1, 1, 1, 1, 2, 2};

  logic [NP-1:0] pins_q;

  always #10 clk_i = ~clk_i;

  irq_line_agg dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_drv),
    .line_o (line_o),
    .cnt_o  (cnt_o)
  );

  function automatic int exp_line(int d, int p);
    int l;
    l = (p + slot0[d]) % 4;
    if (hops[d] > 1) l = (l + slot1[d]) % 4;
    return l;
  endfunction

  function automatic int model_cnt(int l);
    int c;
    c = 0;
    for (int d = 0; d < N_DEV; d++)
      for (int p = 0; p < 4; p++)
        if (pins_q[d*4+p] && exp_line(d, p) == l) c++;
    return c;
  endfunction

  function automatic int cnt_of(int l);
    return int'(cnt_o[l*CW +: CW]);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pin_drv;
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && running) begin
      for (int l = 0; l < 4; l++) begin
        check("R8 model count", cnt_of(l), model_cnt(l));
        check("R5 model line", int'(line_o[l]), int'(model_cnt(l) != 0));
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset held cnt1", cnt_of(1), 0);
    check("R1 reset held line", int'(line_o), 0);
    rst_ni = 1'b1;
    running = 1;
    step();
    check("R1 after reset line", int'(line_o), 0);
    check("R1 after reset cnt0", cnt_of(0), 0);

    // R6 / R2: dev0 slot1 pin0 -> line1
    pin_drv[0] = 1'b1;
    step();
    check("R2 R6 rise cnt1", cnt_of(1), 1);
    check("R5 R6 line", int'(line_o), 4'b0010);

    // R7: dev4 pin0 -> (0+1)%4=1, +5 -> 2 ; dev5 pin1 -> (1+7)%4=0, +5 -> 1
    pin_drv[16] = 1'b1;
    pin_drv[21] = 1'b1;
    step();
    check("R7 bridge cnt2", cnt_of(2), 1);
    check("R7 bridge cnt1", cnt_of(1), 2);
    check("R7 bridge line", int'(line_o), 4'b0110);

    // R4: steady levels leave counts alone
    repeat (3) step();
    check("R4 steady cnt1", cnt_of(1), 2);
    check("R4 steady cnt2", cnt_of(2), 1);

    // R3: falls
    pin_drv[0] = 1'b0;
    step();
    check("R3 fall cnt1", cnt_of(1), 1);
    check("R5 still high", int'(line_o[1]), 1);
    pin_drv[21] = 1'b0;
    pin_drv[16] = 1'b0;
    step();
    check("R3 fall cnt1 zero", cnt_of(1), 0);
    check("R5 line low", int'(line_o), 0);

    // R8: three rises on line1 in one cycle: dev1 p3, dev2 p2, dev3 p1
    pin_drv[7]  = 1'b1;
    pin_drv[10] = 1'b1;
    pin_drv[13] = 1'b1;
    step();
    check("R8 burst cnt1", cnt_of(1), 3);
    // rise and fall on line1 together
    pin_drv[7] = 1'b0;
    pin_drv[0] = 1'b1;
    step();
    check("R8 cancel cnt1", cnt_of(1), 3);
    check("R8 cancel cnt0", cnt_of(0), 0);

    // R10: everything high, each line gets 6
    pin_drv = '1;
    step();
    for (int l = 0; l < 4; l++) check("R10 full count", cnt_of(l), 6);
    pin_drv = '0;
    step();
    for (int l = 0; l < 4; l++) check("R3 all fall", cnt_of(l), 0);

    // random toggling, checked by the model each cycle
    for (int i = 0; i < 3000; i++) begin
      pin_drv = pin_drv ^ NP'($urandom & $urandom & $urandom);
      step();
    end

    // R1: asynchronous reset mid-run
    pin_drv = '1;
    step();
    running = 0;
    pin_drv = '0;
    rst_ni = 1'b0;
    #1;
    for (int l = 0; l < 4; l++) check("R1 async clear", cnt_of(l), 0);
    check("R1 async line", int'(line_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    running = 1;
    step();
    pin_drv[5] = 1'b1; // dev1 pin1 -> (1+2)%4=3
    step();
    check("R6 after reset cnt3", cnt_of(3), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule